// File: doc/BRIEF.md
# Four-Channel Broadcast Configuration Register Front End

This block sits behind the byte-wide command port of a four-channel voice codec and owns its control registers. It keeps a four-bit channel enable mask and, for each channel, eight 8-bit configuration registers. A configuration write lands in the same cycle in every channel whose mask bit is 1. One command can therefore program a single channel, any subset of channels, or all four at once. The all-ones mask is the broadcast case, used to bring many codecs to a common setup. A configuration read returns the addressed register of the lowest-numbered enabled channel.

Bytes arrive on a valid/ready handshake. The first byte of a command is the opcode. Write opcodes take one further data byte. Read opcodes produce one response byte on a single-cycle strobe. A state machine with three states runs the exchange. `S_IDLE` accepts an opcode. Its transitions are: a write opcode goes to `S_DATA`; a read opcode goes to `S_RESP`; an undefined opcode stays in `S_IDLE`. `S_DATA` accepts the data byte, applies the write and returns to `S_IDLE`. `S_RESP` holds the response strobe for one cycle with the command port not ready, then returns to `S_IDLE`.

Top module: `chan_cfg_programmer`

## Requirements
- R1: After reset the enable mask is 0000, every configuration register holds 8'h00, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Opcode 8'h0E followed by a data byte loads the enable mask from data bits [3:0]. Bit i enables channel i. Data bits [7:4] are ignored.
- R3: Opcode 8'h0F yields `rsp_valid` in the cycle after the opcode is accepted, with `rsp_byte` = {4'b0000, mask}.
- R4: Opcode 8'b0001_0rrr (8'h10 to 8'h17) followed by a data byte writes register rrr of every enabled channel. Disabled channels and the other registers keep their values.
- R5: With mask 1111, one configuration write gives all four channels the same value in that register.
- R6: A configuration write made while the mask is 0000 changes no register.
- R7: Opcode 8'b0001_1rrr (8'h18 to 8'h1F) returns register rrr of the lowest-numbered enabled channel, in the cycle after the opcode is accepted. With mask 0000 it returns 8'h00.
- R8: Any other opcode is taken as a single byte. It changes neither the mask nor any register and produces no response.
- R9: `rsp_valid` is a one-cycle pulse, and `cmd_ready` is 0 exactly during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Opcode or data byte |
| cmd_ready | output | 1 | Block accepts a byte this cycle |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_byte | output | 8 | Response byte |

## Verification
The bench steps the enable mask through all sixteen values. For each mask it writes a different register with a value derived from that mask, then reads every register of every channel one at a time. This separates a correct fan-out from writes that reach one channel too many or one too few, or that reach the wrong register. The configuration read is also issued under every mask, which checks that the lowest enabled channel wins and that an empty mask returns zero. Every undefined opcode is then sent in turn, and the bench confirms that the mask and the whole register image are unchanged and that no response appears.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;

    localparam logic [7:0] OPC_MASK_WR = 8'h0E;
    localparam logic [7:0] OPC_MASK_RD = 8'h0F;
    localparam logic [4:0] OPC_CFG_WR_HI = 5'b00010;
    localparam logic [4:0] OPC_CFG_RD_HI = 5'b00011;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MASK_WR,
        OP_MASK_RD,
        OP_CFG_WR,
        OP_CFG_RD
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DATA,
        S_RESP
    } fsm_state_e;

    function automatic op_kind_e decode_op(input logic [7:0] b);
        op_kind_e k;
        if (b == OPC_MASK_WR)
            k = OP_MASK_WR;
        else if (b == OPC_MASK_RD)
            k = OP_MASK_RD;
        else if (b[7:3] == OPC_CFG_WR_HI)
            k = OP_CFG_WR;
        else if (b[7:3] == OPC_CFG_RD_HI)
            k = OP_CFG_RD;
        else
            k = OP_NONE;
        return k;
    endfunction

endpackage

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import chan_cfg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic              cmd_ready,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [DATA_W-1:0] sel_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              mask_we,
    output logic              cfg_we,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_byte
);

    localparam int PAD_W = DATA_W - NUM_CH;

    fsm_state_e          state_q, state_d;
    op_kind_e            kind_q, kind_in;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_W-1:0]   rsp_q, rsp_d;

    assign kind_in  = decode_op(cmd_byte);
    assign rd_idx   = cmd_byte[IDX_W-1:0];
    assign wr_idx   = idx_q;
    assign wr_data  = cmd_byte;
    assign rsp_byte = rsp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= OP_NONE;
            idx_q   <= '0;
            rsp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cmd_valid) begin
                kind_q <= kind_in;
                idx_q  <= cmd_byte[IDX_W-1:0];
                rsp_q  <= rsp_d;
            end
        end
    end

    // outputs and next state
    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        mask_we   = 1'b0;
        cfg_we    = 1'b0;
        rsp_d     = sel_data;
        unique case (state_q)
            S_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    unique case (kind_in)
                        OP_MASK_WR, OP_CFG_WR: state_d = S_DATA;
                        OP_MASK_RD: begin
                            state_d = S_RESP;
                            rsp_d   = {{PAD_W{1'b0}}, en_mask};
                        end
                        OP_CFG_RD:  state_d = S_RESP;
                        default:    state_d = S_IDLE;
                    endcase
                end
            end
            S_DATA: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    mask_we = (kind_q == OP_MASK_WR);
                    cfg_we  = (kind_q == OP_CFG_WR);
                    state_d = S_IDLE;
                end
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R9
    AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_valid && kind_in == OP_NONE)
        |=> (state_q == S_IDLE && !rsp_valid)); // R8

endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4,
    parameter int REGS   = 8,
    parameter int IDX_W  = $clog2(REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [NUM_CH-1:0]             en_mask,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [NUM_CH-1:0][DATA_W-1:0] ch_rd
);

    logic [NUM_CH-1:0][REGS-1:0][DATA_W-1:0] image;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [REGS-1:0][DATA_W-1:0] regs_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q <= '0;
            else if (wr_en && en_mask[c])
                regs_q[wr_idx] <= wr_data;
        end
        assign image[c] = regs_q;
        assign ch_rd[c] = regs_q[rd_idx];
    end

    AST_NO_EN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |=> $stable(image)); // R6
    AST_IDLE_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(image)); // R4

endmodule

// File: rtl/first_enabled_mux.sv
module first_enabled_mux #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]             en_mask,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_rd,
    output logic [DATA_W-1:0]             sel_data
);

    always_comb begin
        sel_data = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (en_mask[c])
                sel_data = ch_rd[c];
        end
    end

endmodule

// File: rtl/chan_cfg_programmer.sv
module chan_cfg_programmer #(
    parameter int NUM_CH = 4,
    parameter int REGS   = 8,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic             cmd_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte
);

    localparam int IDX_W = $clog2(REGS);

    logic [NUM_CH-1:0]             en_mask;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;
    logic [DATA_W-1:0]             sel_data;
    logic [IDX_W-1:0]              rd_idx, wr_idx;
    logic [DATA_W-1:0]             wr_data;
    logic                          mask_we, cfg_we;

    cmd_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .en_mask(en_mask), .sel_data(sel_data), .rd_idx(rd_idx),
        .mask_we(mask_we), .cfg_we(cfg_we), .wr_idx(wr_idx), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_mask <= '0;
        else if (mask_we)
            en_mask <= wr_data[NUM_CH-1:0];
    end

    chan_reg_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .REGS(REGS), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .en_mask(en_mask),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .ch_rd(ch_rd)
    );

    first_enabled_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) mux_i (
        .en_mask(en_mask), .ch_rd(ch_rd), .sel_data(sel_data)
    );

    AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_mask) |-> $past(mask_we)); // R2
    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && en_mask == '0) |-> (rsp_byte == 8'h00)); // R7

endmodule

// File: tb/chan_cfg_programmer_tb_top.sv
module chan_cfg_programmer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_ready, rsp_valid;
    logic [7:0] rsp_byte;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [3:0] mask_m;
    logic [7:0] mdl [4][8];

    always #4 clk = ~clk;

    chan_cfg_programmer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // offer one byte; returns at the negedge after acceptance
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_op(input logic [7:0] op, input string req, output logic [7:0] val);
        send(op);
        check(req, {7'b0, rsp_valid}, 8'h01);
        val = rsp_byte;
        check("R9", {7'b0, cmd_ready}, 8'h00);
        @(negedge clk);
        check("R9", {7'b0, rsp_valid}, 8'h00);
    endtask

    task automatic set_mask(input logic [7:0] d);
        send(8'h0E);
        send(d);
        mask_m = d[3:0];
    endtask

    task automatic cfg_write(input int r, input logic [7:0] d);
        send(8'h10 | 8'(r));
        send(d);
        for (int c = 0; c < 4; c++)
            if (mask_m[c]) mdl[c][r] = d;
    endtask

    function automatic logic [7:0] lowest(input int r);
        for (int c = 0; c < 4; c++)
            if (mask_m[c]) return mdl[c][r];
        return 8'h00;
    endfunction

    // read every register of every channel through single-channel masks
    task automatic verify_image(input string req);
        logic [3:0] keep;
        logic [7:0] v;
        keep = mask_m;
        for (int c = 0; c < 4; c++) begin
            set_mask(8'(1 << c));
            for (int r = 0; r < 8; r++) begin
                read_op(8'h18 | 8'(r), req, v);
                check(req, v, mdl[c][r]);
            end
        end
        set_mask({4'h0, keep});
    endtask

    initial begin
        logic [7:0] v;
        mask_m = 4'h0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 8; r++) mdl[c][r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {7'b0, cmd_ready}, 8'h01);
        check("R1", {7'b0, rsp_valid}, 8'h00);
        read_op(8'h0F, "R1", v);
        check("R1", v, 8'h00);
        read_op(8'h18, "R7", v);
        check("R7", v, 8'h00);
        verify_image("R1");

        // R2 upper data bits ignored, R3 read-back
        set_mask(8'hF5);
        read_op(8'h0F, "R3", v);
        check("R2", v, 8'h05);

        // R6 write with empty mask
        set_mask(8'h00);
        cfg_write(3, 8'h77);
        verify_image("R6");

        // R5 broadcast
        set_mask(8'h0F);
        cfg_write(7, 8'hA5);
        verify_image("R5");

        // R4 sweep all masks
        for (int m = 0; m < 16; m++) begin
            set_mask(8'(m) | 8'hA0);
            read_op(8'h0F, "R3", v);
            check("R3", v, 8'(m));
            cfg_write(m % 8, 8'(m * 17 + 3));
            for (int r = 0; r < 8; r++) begin
                read_op(8'h18 | 8'(r), "R7", v);
                check("R7", v, lowest(r));
            end
            verify_image("R4");
        end

        // R8 undefined opcodes
        set_mask(8'h06);
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h0E && b != 8'h0F && (b < 8'h10 || b > 8'h1F)) begin
                send(8'(b));
                check("R8", {7'b0, rsp_valid}, 8'h00);
            end
        end
        read_op(8'h0F, "R8", v);
        check("R8", v, 8'h06);
        verify_image("R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule